// File: doc/BRIEF.md
# Line-Pooled Constant Decoder

This block is the decode stage of a fetch path for a fixed 32-bit instruction set in which large constants do not sit in the instruction words. Each 64-byte instruction cache line is split in two. Instruction words fill the front of the line. A pool of 16-bit constant packets fills the rest, after the last instruction. An instruction that needs a wide constant names it by a packet index counted from the start of its own line, so no base register is involved. The block takes one whole fetched line per cycle. It marks which of the sixteen 32-bit slots are real instructions, and resolves every constant reference into its value using packets from that same line.

Pool slots are still passed on with the rest of the line, but their valid flag is low, so later stages treat them as NOPs. The block also produces the fetch address of the following line, so straight-line code crosses from the last instruction of one line into the next line without any branch. A taken branch may enter a line part way through. Decoding then starts at the entry slot, and the pool boundary of the line stays where the line's first word puts it. All outputs are registered and appear one cycle after the line is presented.

Top module: `cl_line_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, every bit of slot_valid and every bit of slot_illegal are 0.
- R2: The outputs describe the line presented one cycle earlier. out_valid equals the previous cycle's line_valid. When out_valid is 1, slot_word equals the previous cycle's line_data, with slot k in bits [32k+31:32k].
- R3: Bits [3:0] of slot 0 hold the instruction count minus one, so a line has between 1 and 16 instruction words. Every slot at or beyond the count is a pool slot, and its slot_valid bit is 0.
- R4: Slots below entry_slot have slot_valid 0. The pool boundary is taken from slot 0 even when entry_slot is not 0. An entry_slot inside the pool gives no valid slot.
- R5: When out_valid is 1, next_fetch equals the previous line_addr with its low 6 bits cleared, plus 64.
- R6: A valid slot whose bit 31 is 1 is a constant reference. Bits [9:5] hold the starting packet index p, counted in 16-bit packets from the start of the line. Bits [11:10] hold the packet count minus one, n. Its 64-bit slot_const holds packet p+j at bits [16j+15:16j] for j from 0 to n, and zeros above.
- R7: A constant reference raises its slot_illegal bit when p is less than twice the instruction count, which puts it in the instruction area, or when p+n is greater than 31, which runs past the line. Its slot_const is then 0.
- R8: A slot that is not valid, or whose bit 31 is 0, has slot_const 0 and slot_illegal 0.
- R9: When out_valid is 0, slot_valid and slot_illegal are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_valid | input | 1 | A fetched line is present this cycle |
| line_addr | input | 32 | Byte address of the fetched line |
| entry_slot | input | 4 | First slot to decode; 0 for sequential fetch, the target slot after a taken branch |
| line_data | input | 512 | The whole line, slot k in bits [32k+31:32k] |
| out_valid | output | 1 | Decoded line outputs are meaningful |
| slot_valid | output | 16 | Per-slot flag: slot is a live instruction |
| slot_word | output | 512 | The line's words, passed on for later stages |
| slot_const | output | 1024 | Per-slot resolved constant, 64 bits each, slot k in bits [64k+63:64k] |
| slot_illegal | output | 16 | Per-slot flag: constant reference out of the pool |
| next_fetch | output | 32 | Address of the following line |

## Verification
If the boundary decode is wrong, the error shows one cycle later at slot_valid. Pool slots appear live, or real instructions vanish. slot_illegal and slot_const follow, because the legal packet range depends on the same count. If the packet select is wrong, the wrong 16-bit pieces show up in slot_const for that very line, and the random lines reach every index and length. Each cycle the bench model predicts every slot, so any such fault is caught on the first line that exposes it.

// File: rtl/cl_pkg.sv
package cl_pkg;
   // bit position of the pool-boundary count inside slot 0
   localparam int CL_CNT_LSB = 0;
   // bit position of the packet index inside a constant-referencing word
   localparam int CL_IDX_LSB = 5;

   typedef enum logic [1:0] {
      SK_OFF,
      SK_PLAIN,
      SK_REF,
      SK_BAD
   } slot_kind_e;
endpackage

// File: rtl/cl_bounds.sv
module cl_bounds #(
   parameter int SLOTS = 16,
   parameter int CNT_W = 4,
   parameter int IDX_W = 5
) (
   input  logic [CNT_W-1:0] cnt_field,
   input  logic [CNT_W-1:0] entry,
   input  logic             live,
   output logic [SLOTS-1:0] slot_on,
   output logic [IDX_W:0]   pool_first
);
   logic [CNT_W:0] n_instr;

   assign n_instr    = {1'b0, cnt_field} + 1'b1;
   // pool starts right after the last instruction word, two packets per word
   assign pool_first = {n_instr, 1'b0};

   for (genvar s = 0; s < SLOTS; s++) begin : g_on
      localparam logic [CNT_W:0] SIDX = (CNT_W+1)'(s);
      assign slot_on[s] = live && (SIDX >= {1'b0, entry}) && (SIDX < n_instr);
   end
endmodule

// File: rtl/cl_slot.sv
module cl_slot #(
   parameter int WORD_W  = 32,
   parameter int PKT_W   = 16,
   parameter int NPKT    = 32,
   parameter int IDX_W   = 5,
   parameter int LEN_W   = 2,
   parameter int LINE_W  = 512,
   parameter int CONST_W = 64
) (
   input  logic [LINE_W-1:0]  line,
   input  logic [WORD_W-1:0]  word,
   input  logic               on,
   input  logic [IDX_W:0]     pool_first,
   output logic [CONST_W-1:0] value,
   output logic               illegal
);
   import cl_pkg::*;

   localparam int LEN_LSB = CL_IDX_LSB + IDX_W;
   localparam int MAXP    = 1 << LEN_W;

   logic [IDX_W-1:0] idx;
   logic [LEN_W-1:0] len;
   logic [IDX_W:0]   last;
   slot_kind_e       kind;

   assign idx  = word[CL_IDX_LSB +: IDX_W];
   assign len  = word[LEN_LSB +: LEN_W];
   assign last = {1'b0, idx} + (IDX_W+1)'(len);

   always_comb begin
      if (!on)                                  kind = SK_OFF;
      else if (!word[WORD_W-1])                 kind = SK_PLAIN;
      else if (({1'b0, idx} < pool_first) ||
               (last > (IDX_W+1)'(NPKT-1)))     kind = SK_BAD;
      else                                      kind = SK_REF;
   end

   always_comb begin
      value = '0;
      if (kind == SK_REF) begin
         for (int j = 0; j < MAXP; j++) begin
            if (j <= int'(len))
               value[j*PKT_W +: PKT_W] = line[(int'(idx) + j)*PKT_W +: PKT_W];
         end
      end
   end

   assign illegal = (kind == SK_BAD);
endmodule

// File: rtl/cl_line_decoder.sv
module cl_line_decoder #(
   parameter  int LINE_BYTES = 64,
   parameter  int WORD_W     = 32,
   parameter  int PKT_W      = 16,
   parameter  int LEN_W      = 2,
   parameter  int ADDR_W     = 32,
   localparam int LINE_W     = LINE_BYTES * 8,
   localparam int SLOTS      = LINE_W / WORD_W,
   localparam int NPKT       = LINE_W / PKT_W,
   localparam int CNT_W      = $clog2(SLOTS),
   localparam int IDX_W      = $clog2(NPKT),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int CONST_W    = PKT_W << LEN_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     line_valid,
   input  logic [ADDR_W-1:0]        line_addr,
   input  logic [CNT_W-1:0]         entry_slot,
   input  logic [LINE_W-1:0]        line_data,
   output logic                     out_valid,
   output logic [SLOTS-1:0]         slot_valid,
   output logic [LINE_W-1:0]        slot_word,
   output logic [SLOTS*CONST_W-1:0] slot_const,
   output logic [SLOTS-1:0]         slot_illegal,
   output logic [ADDR_W-1:0]        next_fetch
);
   import cl_pkg::*;

   if (WORD_W != 2 * PKT_W)
      $error("instruction word must hold exactly two constant packets");
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0)
      $error("line size must be a power of two");
   if (CNT_W > CL_IDX_LSB)
      $error("boundary count field overlaps the packet index field");
   if (CL_IDX_LSB + IDX_W + LEN_W > WORD_W - 1)
      $error("reference fields collide with the reference flag bit");

   logic [SLOTS-1:0]         on_c;
   logic [SLOTS-1:0]         ill_c;
   logic [SLOTS*CONST_W-1:0] val_c;
   logic [IDX_W:0]           pool_first;
   logic [ADDR_W-OFF_W-1:0]  line_idx_nxt;

   cl_bounds #(.SLOTS(SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bounds (
      .cnt_field (line_data[CL_CNT_LSB +: CNT_W]),
      .entry     (entry_slot),
      .live      (line_valid),
      .slot_on   (on_c),
      .pool_first(pool_first)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      cl_slot #(
         .WORD_W(WORD_W), .PKT_W(PKT_W), .NPKT(NPKT), .IDX_W(IDX_W),
         .LEN_W(LEN_W), .LINE_W(LINE_W), .CONST_W(CONST_W)
      ) u_slot (
         .line      (line_data),
         .word      (line_data[s*WORD_W +: WORD_W]),
         .on        (on_c[s]),
         .pool_first(pool_first),
         .value     (val_c[s*CONST_W +: CONST_W]),
         .illegal   (ill_c[s])
      );
   end

   // sequential fall-through: next line, no branch needed
   assign line_idx_nxt = line_addr[ADDR_W-1:OFF_W] + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         slot_valid   <= '0;
         slot_illegal <= '0;
      end else begin
         out_valid    <= line_valid;
         slot_valid   <= on_c;
         slot_illegal <= ill_c;
      end
   end

   always_ff @(posedge clk) begin
      if (line_valid) begin
         slot_word  <= line_data;
         slot_const <= val_c;
         next_fetch <= {line_idx_nxt, {OFF_W{1'b0}}};
      end
   end

   // R2: output validity follows the presented line by one cycle
   p_follow_r2: assert property (@(posedge clk) disable iff (rst)
      line_valid |=> out_valid);
   p_drop_r2: assert property (@(posedge clk) disable iff (rst)
      !line_valid |=> !out_valid);

   // R3: nothing at or past the boundary count is marked live
   p_pool_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      line_valid |=> (slot_valid >> ({1'b0, $past(line_data[CL_CNT_LSB +: CNT_W])} + 1'b1)) == '0);

   // R4: slots before the entry point stay dead
   p_entry_r4: assert property (@(posedge clk) disable iff (rst)
      line_valid |=> (slot_valid & ~({SLOTS{1'b1}} << $past(entry_slot))) == '0);

   // R5: fall-through address is the next aligned line
   p_next_r5: assert property (@(posedge clk) disable iff (rst)
      line_valid |=> (next_fetch[OFF_W-1:0] == '0) &&
                     (next_fetch[ADDR_W-1:OFF_W] == $past(line_addr[ADDR_W-1:OFF_W]) + 1'b1));

   // R8: only live slots can be flagged
   p_ill_live_r8: assert property (@(posedge clk) disable iff (rst)
      (slot_illegal & ~slot_valid) == '0);

   // R9: an empty output cycle carries no live or flagged slot
   p_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (slot_valid == '0) && (slot_illegal == '0));
endmodule

// File: tb/sim_cl_line_decoder.sv
module sim_cl_line_decoder;
   logic         clk = 1'b0;
   logic         rst;
   logic         line_valid;
   logic [31:0]  line_addr;
   logic [3:0]   entry_slot;
   logic [511:0] line_data;
   logic         out_valid;
   logic [15:0]  slot_valid;
   logic [511:0] slot_word;
   logic [1023:0] slot_const;
   logic [15:0]  slot_illegal;
   logic [31:0]  next_fetch;

   always #10 clk = ~clk;

   cl_line_decoder u0 (
      .clk(clk), .rst(rst), .line_valid(line_valid), .line_addr(line_addr),
      .entry_slot(entry_slot), .line_data(line_data), .out_valid(out_valid),
      .slot_valid(slot_valid), .slot_word(slot_word), .slot_const(slot_const),
      .slot_illegal(slot_illegal), .next_fetch(next_fetch)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic         e_valid;
   logic [15:0]  e_slot;
   logic [15:0]  e_ill;
   logic [511:0] e_word;
   logic [31:0]  e_next;
   logic [63:0]  e_const [16];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural model of what the next clock edge must produce
   task automatic predict();
      int cnt, pool;
      e_valid = line_valid;
      e_slot  = '0;
      e_ill   = '0;
      for (int s = 0; s < 16; s++) e_const[s] = '0;
      if (line_valid) begin
         e_word = line_data;
         e_next = ((line_addr / 64) + 1) * 64;
         cnt    = int'(line_data[3:0]) + 1;
         pool   = 2 * cnt;
         for (int s = 0; s < 16; s++) begin
            logic [31:0] w;
            int idx, len;
            w = line_data[s*32 +: 32];
            if (s >= int'(entry_slot) && s < cnt) begin
               e_slot[s] = 1'b1;
               if (w[31]) begin
                  idx = int'(w[9:5]);
                  len = int'(w[11:10]);
                  if (idx < pool || idx + len > 31) e_ill[s] = 1'b1;
                  else
                     for (int j = 0; j <= len; j++)
                        e_const[s][j*16 +: 16] = line_data[(idx+j)*16 +: 16];
               end
            end
         end
      end
   endtask

   task automatic compare();
      chk("R2 out_valid", 64'(out_valid), 64'(e_valid));
      chk("R3 R4 slot_valid", 64'(slot_valid), 64'(e_slot));
      chk("R7 R8 slot_illegal", 64'(slot_illegal), 64'(e_ill));
      if (!e_valid) begin
         chk("R9 idle slot_valid", 64'(slot_valid), 64'd0);
      end else begin
         for (int s = 0; s < 16; s++)
            chk("R2 slot_word", 64'(slot_word[s*32 +: 32]), 64'(e_word[s*32 +: 32]));
         for (int s = 0; s < 16; s++)
            chk("R6 R8 slot_const", slot_const[s*64 +: 64], e_const[s]);
         chk("R5 next_fetch", 64'(next_fetch), 64'(e_next));
      end
   endtask

   function automatic logic [31:0] ref_word(int idx, int len);
      logic [31:0] w;
      w = $urandom;
      w[31] = 1'b1;
      w[9:5] = 5'(idx);
      w[11:10] = 2'(len);
      return w;
   endfunction

   task automatic make_vec(int k);
      line_data  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                    $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      line_addr  = $urandom;
      line_valid = 1'b1;
      entry_slot = 4'd0;
      case (k)
         0: begin // R3: all sixteen slots are instructions, plain words
            for (int s = 0; s < 16; s++) line_data[s*32+31] = 1'b0;
            line_data[3:0] = 4'd15;
         end
         1: begin // R6: single instruction, reference to first pool packet, four packets
            line_data[31:0] = ref_word(2, 3);
            line_data[3:0] = 4'd0;
         end
         2: begin // R7: exactly at pool start legal, one packet below illegal
            line_data[3:0] = 4'd3;
            line_data[1*32 +: 32] = ref_word(8, 1);
            line_data[2*32 +: 32] = ref_word(7, 0);
         end
         3: begin // R7: last packet legal alone, illegal when it runs past the line
            line_data[3:0] = 4'd2;
            line_data[1*32 +: 32] = ref_word(31, 0);
            line_data[2*32 +: 32] = ref_word(31, 1);
         end
         4: begin // R4: branch entry in the middle, boundary from slot 0
            line_data[3:0] = 4'd9;
            entry_slot = 4'd5;
            line_data[5*32 +: 32] = ref_word(20, 2);
         end
         5: begin // R4: entry lands inside the pool
            line_data[3:0] = 4'd4;
            entry_slot = 4'd7;
         end
         6: line_valid = 1'b0; // R9: idle cycle with junk on the inputs
         default: begin
            line_data[3:0] = 4'($urandom_range(15, 0));
            for (int s = 0; s < 16; s++)
               if ($urandom_range(1, 0) == 1) line_data[s*32+31] = 1'b1;
            if ($urandom_range(3, 0) == 0) entry_slot = 4'($urandom_range(15, 0));
            if ($urandom_range(7, 0) == 0) line_valid = 1'b0;
         end
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      line_valid = 1'b0;
      line_addr = '0;
      entry_slot = '0;
      line_data = '0;
      repeat (3) @(negedge clk);
      // R1: outputs cleared under reset
      chk("R1 out_valid", 64'(out_valid), 64'd0);
      chk("R1 slot_valid", 64'(slot_valid), 64'd0);
      chk("R1 slot_illegal", 64'(slot_illegal), 64'd0);
      rst = 1'b0;
      predict();
      for (int k = 0; k < 800; k++) begin
         @(negedge clk);
         compare();
         make_vec(k);
         predict();
      end
      @(negedge clk);
      compare();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule